// File: doc/BRIEF.md
# SPI Controller with FIFO-Gated Chip Select

This block is an SPI controller for a host that moves data one byte at a time. The host writes bytes into a four-entry transmit queue. When the shifter is free, the oldest queued byte moves into it straight away, so a burst written to an idle block is accepted five bytes deep before the queue reports full. Each byte goes out MSB first on `mosi` while one byte is captured from the receive line. Received bytes collect in a four-entry receive queue, which the host reads from its head.

The host sets clock polarity, clock phase, a divider for the serial clock, and an internal loopback that feeds `mosi` back to the receiver. Chip select is driven by the block. With phase 0 it is released after every byte. With phase 1 it stays low from one byte to the next only while the transmit queue still holds a byte at the moment the current byte completes. So whether a multi-byte transfer stays under one chip-select window depends on how far ahead the host filled the queue.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: The transmit path holds five bytes in total: four queue entries plus the shifter. After an uninterrupted burst of writes to an idle block, exactly five are accepted and `tx_full` is high. A write while `tx_full` is high is discarded and never appears on `mosi`.
- R2: Each byte is shifted out MSB first. Per byte, `sclk` makes 16 transitions and `mosi` carries the eight bits in order from bit 7 down to bit 0.
- R3: With `cfg_cpha`=0, `cs_n` goes high after every byte, so each low window holds exactly 16 `sclk` transitions. Between windows `cs_n` stays high for at least `cfg_div`+1 system clocks.
- R4: With `cfg_cpha`=1, bytes that are already queued when the previous byte completes are sent under one `cs_n` low window, with 16 transitions per byte.
- R5: With `cfg_cpha`=1, if the transmit queue is empty when a byte completes, `cs_n` goes high. A byte written later opens a new window.
- R6: With `cfg_loop`=1 the received byte equals the byte sent. With `cfg_loop`=0 the received byte is the byte sampled from `miso`.
- R7: `busy` is high while a byte is queued or the shifter or its chip-select release interval is active. Whenever `busy` is low, `cs_n` is high.
- R8: The receive queue holds four bytes and presents its head on `rx_data` when `rx_empty` is low. `rx_rd` removes the head. If a byte completes while the queue is full, that byte is dropped and `rx_ovf` is set. `rx_ovf` stays set until the next `rx_rd`.
- R9: Each half period of `sclk` lasts `cfg_div`+1 system clocks. While `cs_n` is high, `sclk` rests at `cfg_cpol` and does not toggle.
- R10: After reset, `cs_n`=1, `busy`=0, `tx_full`=0, `rx_empty`=1, `rx_ovf`=0 and `sclk` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: sample on first edge; 1: sample on second edge |
| cfg_loop | input | 1 | 1: receiver takes `mosi` instead of `miso` |
| cfg_div | input | 8 | Half period of `sclk` minus one, in system clocks |
| tx_wr | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full; writes are discarded |
| rx_rd | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | A received byte was dropped because the queue was full |
| busy | output | 1 | Transfer in progress or pending |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle:
- `sclk` holds at its idle level and never toggles while chip select is high.
- Chip select is never low while the block is not busy.
- A full transmit queue implies busy.
- The overflow flag stays set until a read, and it can only rise while the receive queue holds data.

Other behaviour can only be shown by the bench scenarios, because it depends on how a whole transfer unfolds:
- the five-byte acceptance depth;
- the count of `sclk` transitions in each chip-select window under each phase and queue fill;
- the MSB-first bit order on `mosi`;
- the minimum chip-select high time;
- loopback versus external receive data;
- which byte is lost on a receive overflow.

// File: rtl/spi_ctl_pkg.sv
// Package: shared parameters and state encoding for the SPI controller.
// Assumes byte-wide data; all sizes below derive from these values.
package spi_ctl_pkg;
    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 4;
    localparam int DIV_W      = 8;
    localparam int EDGES      = 2 * DATA_W;
    localparam int ECNT_W     = $clog2(EDGES);

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_byte_fifo.sv
// Module: spi_byte_fifo
// Synchronous first-word-fall-through queue. The head is always visible on
// rd_data when empty is low. Assumes the caller gates push with !full and
// pop with !empty; an ungated request is ignored.
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wr_data;
        end
    end

    // Advance pointers and occupancy on accepted push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            end
            if (do_pop) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            end
            if (do_push && !do_pop) begin
                count <= count + CW'(1);
            end else if (do_pop && !do_push) begin
                count <= count - CW'(1);
            end
        end
    end
endmodule

// File: rtl/spi_half_tick.sv
// Module: spi_half_tick
// Emits one tick every div+1 cycles while run is high. The count restarts
// from zero whenever run is low, so the first tick after run rises comes
// div+1 cycles later.
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count system clocks within one half period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spi_bit_engine.sv
// Module: spi_bit_engine
// Serialises one byte at a time, MSB first, and captures one byte per byte
// sent. It loads the queue head as soon as the queue is non-empty and idle.
// In phase-1 mode it chains straight into the next byte if one is queued
// when the current byte completes. Otherwise it releases chip select for
// one half period before it can start again.
// Assumes the configuration inputs are held stable while active is high.
module spi_bit_engine
    import spi_ctl_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int DVW = DIV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpol,
    input  logic           cpha,
    input  logic [DVW-1:0] div,
    input  logic           tx_empty,
    input  logic [DW-1:0]  tx_head,
    output logic           tx_pop,
    input  logic           miso_in,
    output logic           rx_push,
    output logic [DW-1:0]  rx_byte,
    output logic           sclk,
    output logic           mosi,
    output logic           cs_n,
    output logic           active
);
    localparam int NEDGE = 2 * DW;
    localparam int EW    = $clog2(NEDGE);

    eng_state_t    state;
    logic [EW-1:0] ecnt;
    logic          phase;
    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;
    logic          tick;
    logic          lead;
    logic          last;
    logic          do_shift;
    logic          do_sample;
    logic          chain;
    logic          start;

    spi_half_tick #(.DIV_W(DVW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .div   (div),
        .tick  (tick)
    );

    assign active = (state != ENG_IDLE);
    assign cs_n   = (state != ENG_SHIFT);
    assign sclk   = cpol ^ phase;
    assign mosi   = tx_sr[DW-1];

    // Decode which action the current serial clock edge performs.
    always_comb begin
        lead      = !ecnt[0];
        last      = (ecnt == EW'(NEDGE - 1));
        do_shift  = cpha ? (lead && (ecnt != '0)) : (!lead && !last);
        do_sample = cpha ? !lead : lead;
        chain     = cpha && !tx_empty;
        start     = (state == ENG_IDLE) && !tx_empty;
        rx_push   = (state == ENG_SHIFT) && tick && last;
        rx_byte   = (do_sample) ? {rx_sr[DW-2:0], miso_in} : rx_sr;
        tx_pop    = start || (rx_push && chain);
    end

    // Sequence load, edge-by-edge shifting, chaining and chip-select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
            ecnt  <= '0;
            phase <= 1'b0;
            tx_sr <= '0;
            rx_sr <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state <= ENG_SHIFT;
                        tx_sr <= tx_head;
                        ecnt  <= '0;
                        phase <= 1'b0;
                    end
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        phase <= ~phase;
                        ecnt  <= ecnt + EW'(1);
                        if (do_shift) begin
                            tx_sr <= {tx_sr[DW-2:0], 1'b0};
                        end
                        if (do_sample) begin
                            rx_sr <= {rx_sr[DW-2:0], miso_in};
                        end
                        if (last) begin
                            if (chain) begin
                                tx_sr <= tx_head;
                                ecnt  <= '0;
                            end else begin
                                state <= ENG_GAP;
                            end
                        end
                    end
                end
                ENG_GAP: begin
                    if (tick) begin
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_fifo_ctrl.sv
// Module: spi_fifo_ctrl (top)
// Byte-oriented SPI controller: a transmit queue feeding the bit engine, a
// receive queue with a sticky overflow flag, and an optional loopback from
// mosi to the receiver. Assumes cfg_* change only while busy is low.
module spi_fifo_ctrl
    import spi_ctl_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DVW   = DIV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_cpol,
    input  logic           cfg_cpha,
    input  logic           cfg_loop,
    input  logic [DVW-1:0] cfg_div,
    input  logic           tx_wr,
    input  logic [DW-1:0]  tx_data,
    output logic           tx_full,
    input  logic           rx_rd,
    output logic [DW-1:0]  rx_data,
    output logic           rx_empty,
    output logic           rx_ovf,
    output logic           busy,
    output logic           sclk,
    output logic           mosi,
    output logic           cs_n,
    input  logic           miso
);
    logic          tx_empty;
    logic [DW-1:0] tx_head;
    logic          tx_pop;
    logic          rx_full;
    logic          eng_push;
    logic [DW-1:0] eng_byte;
    logic          eng_active;
    logic          miso_in;
    logic          ovf_hit;

    assign miso_in = cfg_loop ? mosi : miso;
    assign ovf_hit = eng_push && rx_full;
    assign busy    = eng_active || !tx_empty;

    spi_byte_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (tx_wr),
        .wr_data (tx_data),
        .pop     (tx_pop),
        .rd_data (tx_head),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    spi_bit_engine #(.DW(DW), .DVW(DVW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .div      (cfg_div),
        .tx_empty (tx_empty),
        .tx_head  (tx_head),
        .tx_pop   (tx_pop),
        .miso_in  (miso_in),
        .rx_push  (eng_push),
        .rx_byte  (eng_byte),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .active   (eng_active)
    );

    spi_byte_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (eng_push),
        .wr_data (eng_byte),
        .pop     (rx_rd),
        .rd_data (rx_data),
        .full    (rx_full),
        .empty   (rx_empty)
    );

    // Hold the overflow flag from a dropped byte until the host reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ovf <= 1'b0;
        end else if (ovf_hit) begin
            rx_ovf <= 1'b1;
        end else if (rx_rd) begin
            rx_ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_fifo_ctrl_chk.sv
// Module: spi_fifo_ctrl_chk
// Cycle-by-cycle properties on the controller's ports, bound to the top.
module spi_fifo_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cpol,
    input logic sclk,
    input logic cs_n,
    input logic busy,
    input logic tx_full,
    input logic rx_rd,
    input logic rx_empty,
    input logic rx_ovf
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (sclk == cfg_cpol)); // R9
    AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk ^ cfg_cpol) |-> !$past(cs_n)); // R9
    AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R7
    AST_FULL_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> busy); // R1
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !rx_rd) |=> rx_ovf); // R8
    AST_OVF_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> !rx_empty); // R8
endmodule

bind spi_fifo_ctrl spi_fifo_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cpol (cfg_cpol),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .busy     (busy),
    .tx_full  (tx_full),
    .rx_rd    (rx_rd),
    .rx_empty (rx_empty),
    .rx_ovf   (rx_ovf)
);

// File: tb/spi_fifo_ctrl_test.sv
// Bench: directed corner cases plus seeded random bursts. A negedge monitor
// rebuilds chip-select windows, edge spacing and mosi bytes from the pins.
module spi_fifo_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cpha = 1'b0;
    logic       cfg_loop = 1'b1;
    logic [7:0] cfg_div = 8'd1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_full;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_empty;
    logic       rx_ovf;
    logic       busy;
    logic       sclk;
    logic       mosi;
    logic       cs_n;
    logic       miso;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // external device model: returns the inverted transmit bit
    assign miso = ~mosi;

    always #4 clk = ~clk;

    spi_fifo_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_loop(cfg_loop), .cfg_div(cfg_div), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_empty(rx_empty), .rx_ovf(rx_ovf),
        .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    // monitor state
    logic       mon_clr = 1'b0;
    int         nwin, edges, bad_period, bad_idle, cyc_since, hi_len, min_hi;
    int         wins [0:15];
    logic [7:0] mon_bytes [0:15];
    int         nmon, nbits;
    logic [7:0] acc;
    logic       p_cs, p_sclk, p_mosi;

    // Reconstruct windows, edge timing and sampled mosi bytes from the pins.
    always @(negedge clk) begin
        if (mon_clr || !rst_n) begin
            nwin = 0; edges = 0; bad_period = 0; bad_idle = 0;
            cyc_since = 0; hi_len = 0; min_hi = 1000000; nmon = 0;
            nbits = 0; acc = 0;
        end else begin
            cyc_since++;
            if (p_cs && !cs_n) begin
                if (nwin > 0 && hi_len < min_hi) min_hi = hi_len;
                edges = 0;
            end
            if (!p_cs && sclk != p_sclk) begin
                if (edges > 0 && cyc_since != int'(cfg_div) + 1) bad_period++;
                cyc_since = 0;
                edges++;
                if (cfg_cpha ? (sclk == cfg_cpol) : (sclk != cfg_cpol)) begin
                    acc = {acc[6:0], p_mosi};
                    nbits++;
                    if (nbits == 8) begin
                        if (nmon < 16) mon_bytes[nmon] = acc;
                        nmon++;
                        nbits = 0;
                    end
                end
            end
            if (!p_cs && cs_n) begin
                if (nwin < 16) wins[nwin] = edges;
                nwin++;
                hi_len = 0;
            end
            if (cs_n) hi_len++;
            if (cs_n && p_cs && sclk != cfg_cpol) bad_idle++;
        end
        p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    logic [7:0] tx_vec [0:7];
    logic [7:0] rx_got [0:7];
    int accepted, nrx;

    task automatic push_seq(input int n);
        accepted = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!tx_full) accepted++;
            tx_wr = 1'b1;
            tx_data = tx_vec[i];
        end
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        nrx = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rx_rd = 1'b0;
            if (rx_empty) break;
            rx_got[nrx] = rx_data;
            nrx++;
            rx_rd = 1'b1;
        end
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    function automatic logic [7:0] expect_rx(input logic [7:0] b, input logic lp);
        return lp ? b : ~b;
    endfunction

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7 actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        // R10: reset state
        check(cs_n == 1'b1, "R10 cs_n", int'(cs_n), 1);
        check(busy == 1'b0, "R10 busy", int'(busy), 0);
        check(tx_full == 1'b0, "R10 tx_full", int'(tx_full), 0);
        check(rx_empty == 1'b1, "R10 rx_empty", int'(rx_empty), 1);
        check(rx_ovf == 1'b0, "R10 rx_ovf", int'(rx_ovf), 0);
        check(sclk == cfg_cpol, "R10 sclk", int'(sclk), int'(cfg_cpol));
        rst_n = 1'b1;
        clear_mon();

        // Directed: phase 1 burst of eight writes from idle.
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_loop = 1'b1; cfg_div = 8'd1;
        for (int i = 0; i < 8; i++) tx_vec[i] = 8'(8'h11 * (i + 1));
        push_seq(8);
        check(accepted == 5, "R1 accepted", accepted, 5);
        check(tx_full == 1'b1, "R1 tx_full", int'(tx_full), 1);
        check(busy == 1'b1, "R7 busy during burst", int'(busy), 1);
        wait_idle();
        check(busy == 1'b0, "R7 busy after", int'(busy), 0);
        check(nwin == 1, "R4 windows", nwin, 1);
        check(wins[0] == 80, "R4 edges", wins[0], 80);
        check(nmon == 5, "R1 mosi byte count", nmon, 5);
        for (int i = 0; i < 5; i++)
            check(mon_bytes[i] == tx_vec[i], "R2 mosi byte", int'(mon_bytes[i]), int'(tx_vec[i]));
        check(rx_ovf == 1'b1, "R8 overflow set", int'(rx_ovf), 1);
        drain();
        check(nrx == 4, "R8 rx depth", nrx, 4);
        for (int i = 0; i < 4; i++)
            check(rx_got[i] == tx_vec[i], "R6 R8 loopback rx", int'(rx_got[i]), int'(tx_vec[i]));
        check(rx_ovf == 1'b0, "R8 overflow cleared", int'(rx_ovf), 0);
        check(bad_period == 0, "R9 half period", bad_period, 0);
        check(bad_idle == 0, "R9 idle level", bad_idle, 0);

        // Directed: phase 0, external receive data, slower clock.
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_loop = 1'b0; cfg_div = 8'd2;
        clear_mon();
        tx_vec[0] = 8'hA5; tx_vec[1] = 8'h3C; tx_vec[2] = 8'h81;
        push_seq(3);
        wait_idle();
        check(nwin == 3, "R3 windows", nwin, 3);
        for (int i = 0; i < 3; i++)
            check(wins[i] == 16, "R3 edges per window", wins[i], 16);
        check(min_hi >= 3, "R3 cs high time", min_hi, 3);
        drain();
        check(nrx == 3, "R6 rx count", nrx, 3);
        for (int i = 0; i < 3; i++)
            check(rx_got[i] == expect_rx(tx_vec[i], 1'b0), "R6 external rx",
                  int'(rx_got[i]), int'(expect_rx(tx_vec[i], 1'b0)));
        check(bad_period == 0, "R9 half period div2", bad_period, 0);
        check(bad_idle == 0, "R9 idle level cpol1", bad_idle, 0);

        // Directed: phase 1 with the queue running dry between two pairs.
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_loop = 1'b1; cfg_div = 8'd0;
        clear_mon();
        tx_vec[0] = 8'h01; tx_vec[1] = 8'h80;
        push_seq(2);
        wait_idle();
        tx_vec[0] = 8'hFE; tx_vec[1] = 8'h7F;
        push_seq(2);
        wait_idle();
        check(nwin == 2, "R5 windows", nwin, 2);
        check(wins[0] == 32, "R5 first window", wins[0], 32);
        check(wins[1] == 32, "R5 second window", wins[1], 32);
        drain();
        check(nrx == 4, "R5 rx count", nrx, 4);

        // Random bursts of one to four bytes.
        for (int t = 0; t < 16; t++) begin
            int n;
            cfg_cpol = 1'($urandom);
            cfg_cpha = 1'($urandom);
            cfg_loop = 1'($urandom);
            cfg_div  = 8'($urandom_range(0, 3));
            n = $urandom_range(1, 4);
            for (int i = 0; i < n; i++) tx_vec[i] = 8'($urandom);
            clear_mon();
            push_seq(n);
            wait_idle();
            check(accepted == n, "R1 random accepted", accepted, n);
            check(nwin == (cfg_cpha ? 1 : n), "R3 R4 random windows", nwin, cfg_cpha ? 1 : n);
            check(wins[0] == (cfg_cpha ? 16 * n : 16), "R3 R4 random edges",
                  wins[0], cfg_cpha ? 16 * n : 16);
            check(nmon == n, "R2 random mosi count", nmon, n);
            for (int i = 0; i < n; i++)
                check(mon_bytes[i] == tx_vec[i], "R2 random mosi", int'(mon_bytes[i]), int'(tx_vec[i]));
            check(bad_period == 0, "R9 random period", bad_period, 0);
            check(bad_idle == 0, "R9 random idle", bad_idle, 0);
            drain();
            check(nrx == n, "R8 random rx count", nrx, n);
            for (int i = 0; i < n; i++)
                check(rx_got[i] == expect_rx(tx_vec[i], cfg_loop), "R6 random rx",
                      int'(rx_got[i]), int'(expect_rx(tx_vec[i], cfg_loop)));
            check(rx_ovf == 1'b0, "R8 no overflow", int'(rx_ovf), 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule